// File: doc/BRIEF.md
# Interrupt Sampling and Acknowledge Unit

This block sits in front of a small 8-bit controller core. It turns six interrupt sources into request flags, decides which flag is serviced, and asks the core for a hardware call. The six sources are two active-low external pins, two timer overflows, a serial receive/transmit pair and a third timer with an overflow and an external event. Time is counted in machine cycles. The core supplies two phase strobes in each machine cycle: an early strobe and a late strobe. Sources are latched on those strobes. Polling takes place on the late strobe, using the flag values that were held before that strobe.

When a request is enabled, wins arbitration, is not blocked by the level already in service, and arrives while the core reports the final cycle of an ordinary instruction, the block acknowledges it. On acknowledgement it produces a one-clock pulse, the source number and a vector address, and it holds a call-busy line for two machine cycles. Two in-progress bits record which priority levels are being serviced. A return-from-interrupt reported by the core clears the higher of the two bits first.

Top module: `irq_front`

## Requirements
- R1: Each external pin is active low. In level mode (`ext_edge` bit = 0), its flag takes the inverted pin level at every late strobe, ignores `flag_clr` and is not cleared on acknowledgement.
- R2: In edge mode (`ext_edge` bit = 1), a flag is set when the pin was high at one late strobe and is low at the next. A pin that stays low does not set the flag again.
- R3: The timer 0 and timer 1 overflow flags, the serial flags and the timer 2 external flag are set at a late strobe. A flag set at a late strobe is first polled at the late strobe of the following machine cycle.
- R4: The timer 2 overflow flag is set at the early strobe and is acknowledged at the late strobe of the same machine cycle.
- R5: A source is eligible only when `glb_en` is 1 and its own bit of `src_en` is 1.
- R6: Source numbers are ext0=0, timer0=1, ext1=2, timer1=3, serial=4 and timer2=5. A source whose `pri_reg` bit is 1 wins over any low-level source. Within one level, the lowest source number wins.
- R7: A low-level request waits while either level is in progress. A high-level request waits only while the high level is in progress, so it can preempt a low-level routine.
- R8: Acknowledgement happens only at a late strobe where `insn_last` is 1 and both `insn_reti` and `insn_cfg` are 0.
- R9: On acknowledgement, `ack_stb` pulses for exactly one clock. `ack_id` gives the source number and `call_vec` gives 0x03 + 8 × source number. `call_busy` rises together with `ack_stb` and falls at the second late strobe after the one that acknowledged.
- R10: Acknowledgement sets `in_prog[1]` for a high-level source or `in_prog[0]` for a low-level source. A late strobe with `insn_last` and `insn_reti` both 1 clears `in_prog[1]` if it is set, and otherwise clears `in_prog[0]`. After reset all flags, `in_prog` and `call_busy` are 0.
- R11: Acknowledgement clears an edge-mode external flag (`flag_q` bits 0 and 2) and the timer overflow flags (bits 1 and 3). It leaves the serial flags (bits 4 rx, 5 tx) and the timer 2 flags (bits 6 overflow, 7 external) alone. A 1 in `flag_clr` clears the corresponding non-level flag.
- R12: No acknowledgement happens while `call_busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| stb_early | input | 1 | Early phase strobe, once per machine cycle |
| stb_late | input | 1 | Late phase strobe, once per machine cycle |
| ext_n | input | 2 | External request pins, active low |
| ext_edge | input | 2 | 1 = edge mode, 0 = level mode, per pin |
| t0_ovf | input | 1 | Timer 0 overflow event |
| t1_ovf | input | 1 | Timer 1 overflow event |
| ser_rx | input | 1 | Serial receive done event |
| ser_tx | input | 1 | Serial transmit done event |
| t2_ovf | input | 1 | Timer 2 overflow event |
| t2_ext | input | 1 | Timer 2 external event |
| flag_clr | input | 8 | Software clear, one bit per flag |
| glb_en | input | 1 | Global enable |
| src_en | input | 6 | Per-source enable |
| pri_reg | input | 6 | Per-source high-priority select |
| insn_last | input | 1 | Core is in the final cycle of an instruction |
| insn_reti | input | 1 | Current instruction is a return from interrupt |
| insn_cfg | input | 1 | Current instruction accesses the enable or priority register |
| flag_q | output | 8 | Request flags |
| in_prog | output | 2 | In-progress bits {high, low} |
| ack_stb | output | 1 | One-clock acknowledge pulse |
| ack_id | output | 3 | Acknowledged source number |
| call_busy | output | 1 | Hardware call in progress |
| call_vec | output | 8 | Call vector address |

## Verification
Every ordered pair of distinct sources is raised at the same late strobe twice. In the first pass both sources share one level, which checks the fixed order within a level. In the second pass the later source is made high priority, which checks that the level overrides the order. Single-source sequences separate the two strobe paths: timer 2 overflow is acknowledged in the same machine cycle, while every other source waits a cycle. Further sequences hold a second request against the call window, the in-progress levels and each core status line. These show that a blocked request is delayed rather than lost. Level and edge pins are exercised separately, so that flag following, one-shot setting and the selective clearing on acknowledgement can each be told apart.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSRC  = 6;
  localparam int NFLAG = 8;
  localparam int IDW   = 3;

  localparam int F_RX   = 4;
  localparam int F_TX   = 5;
  localparam int F_T2OV = 6;
  localparam int F_T2EX = 7;

  // Lowest-numbered set bit wins; the result is 0 when nothing is set.
  function automatic logic [IDW-1:0] lowest_set(input logic [NSRC-1:0] v);
    logic [IDW-1:0] r;
    r = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (v[i]) r = IDW'(i);
    end
    return r;
  endfunction

  function automatic logic [7:0] vec_of(input logic [IDW-1:0] id,
                                        input int base, input int stride);
    return 8'(base + stride * int'(id));
  endfunction
endpackage

// File: rtl/irq_capture.sv
module irq_capture
  import irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stb_early,
  input  logic             stb_late,
  input  logic [1:0]       ext_n,
  input  logic [1:0]       ext_edge,
  input  logic [1:0]       tmr_ovf,
  input  logic             ser_rx,
  input  logic             ser_tx,
  input  logic             t2_ovf,
  input  logic             t2_ext,
  input  logic [NFLAG-1:0] flag_clr,
  input  logic             ack_fire,
  input  logic [IDW-1:0]   ack_src,
  output logic [NFLAG-1:0] flag_q,
  output logic [NSRC-1:0]  src_req
);
  logic rx_f, tx_f, t2ov_f, t2ex_f;

  // Each channel pairs an external pin (source 2g) with a timer (source 2g+1).
  for (genvar g = 0; g < 2; g++) begin : g_chan
    logic ext_f, ext_prev, tmr_f;
    logic ext_ack, tmr_ack, fall_seen;

    assign ext_ack   = ack_fire && (ack_src == IDW'(2 * g));
    assign tmr_ack   = ack_fire && (ack_src == IDW'(2 * g + 1));
    assign fall_seen = stb_late && ext_prev && !ext_n[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ext_f    <= 1'b0;
        ext_prev <= 1'b1;
      end else begin
        if (stb_late) ext_prev <= ext_n[g];
        if (!ext_edge[g]) begin
          if (stb_late) ext_f <= ~ext_n[g];
        end else if (fall_seen) begin
          ext_f <= 1'b1;
        end else if (ext_ack || flag_clr[2*g]) begin
          ext_f <= 1'b0;
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              tmr_f <= 1'b0;
      else if (stb_late && tmr_ovf[g])         tmr_f <= 1'b1;
      else if (tmr_ack || flag_clr[2*g + 1])   tmr_f <= 1'b0;
    end

    assign flag_q[2*g]     = ext_f;
    assign flag_q[2*g + 1] = tmr_f;
    assign src_req[2*g]     = ext_f;
    assign src_req[2*g + 1] = tmr_f;
  end

  // Serial and timer 2 flags are never cleared by acknowledgement.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_f   <= 1'b0;
      tx_f   <= 1'b0;
      t2ov_f <= 1'b0;
      t2ex_f <= 1'b0;
    end else begin
      if (stb_late && ser_rx)       rx_f <= 1'b1;
      else if (flag_clr[F_RX])      rx_f <= 1'b0;
      if (stb_late && ser_tx)       tx_f <= 1'b1;
      else if (flag_clr[F_TX])      tx_f <= 1'b0;
      if (stb_early && t2_ovf)      t2ov_f <= 1'b1;
      else if (flag_clr[F_T2OV])    t2ov_f <= 1'b0;
      if (stb_late && t2_ext)       t2ex_f <= 1'b1;
      else if (flag_clr[F_T2EX])    t2ex_f <= 1'b0;
    end
  end

  assign flag_q[F_RX]   = rx_f;
  assign flag_q[F_TX]   = tx_f;
  assign flag_q[F_T2OV] = t2ov_f;
  assign flag_q[F_T2EX] = t2ex_f;
  assign src_req[4]     = rx_f | tx_f;
  assign src_req[5]     = t2ov_f | t2ex_f;

  // R3: flags move only on a strobe, an acknowledgement or a software clear
  a_r3_flags_on_events: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(stb_late) && !$past(stb_early) && !$past(ack_fire) && ($past(flag_clr) == '0))
      |-> $stable(flag_q));
  // R4: the early strobe can only set the timer 2 overflow flag among the late-strobe flags
  a_r4_early_only_t2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(stb_early) && !$past(stb_late) && ($past(flag_clr) == '0) && !$past(ack_fire))
      |-> (flag_q[5:0] == $past(flag_q[5:0])));
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_req,
  input  logic            glb_en,
  input  logic [NSRC-1:0] src_en,
  input  logic [NSRC-1:0] pri_reg,
  input  logic [1:0]      in_prog,
  output logic            cand_valid,
  output logic [IDW-1:0]  cand_id,
  output logic            cand_hi
);
  logic [NSRC-1:0] pend, pend_hi, pend_lo;
  logic            hi_ok, lo_ok;

  assign pend    = src_req & src_en & {NSRC{glb_en}};
  assign pend_hi = pend & pri_reg;
  assign pend_lo = pend & ~pri_reg;
  assign hi_ok   = (|pend_hi) && !in_prog[1];
  assign lo_ok   = (|pend_lo) && (in_prog == 2'b00);

  always_comb begin
    cand_valid = hi_ok || lo_ok;
    cand_hi    = hi_ok;
    cand_id    = hi_ok ? lowest_set(pend_hi) : lowest_set(pend_lo);
  end

  // R7: a low-level candidate never appears while any level is being serviced
  a_r7_low_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_valid && !cand_hi) |-> (in_prog == 2'b00));
  // R7: a high-level candidate never appears while the high level is being serviced
  a_r7_high_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_valid && cand_hi) |-> !in_prog[1]);
  // R5: a candidate is always a raised and enabled source
  a_r5_enabled_only: assert property (@(posedge clk) disable iff (!rst_n)
    cand_valid |-> (glb_en && src_en[cand_id] && src_req[cand_id]));
endmodule

// File: rtl/irq_sequencer.sv
module irq_sequencer
  import irq_pkg::*;
#(
  parameter int CALL_CYC   = 2,
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           stb_late,
  input  logic           cand_valid,
  input  logic [IDW-1:0] cand_id,
  input  logic           cand_hi,
  input  logic           insn_last,
  input  logic           insn_reti,
  input  logic           insn_cfg,
  output logic           ack_fire,
  output logic           ack_stb,
  output logic [IDW-1:0] ack_id,
  output logic           call_busy,
  output logic [7:0]     call_vec,
  output logic [1:0]     in_prog
);
  localparam int CW = $clog2(CALL_CYC + 1);

  logic [CW-1:0] call_cnt;
  logic          reti_done;

  assign call_busy = (call_cnt != '0);
  assign ack_fire  = stb_late && cand_valid && insn_last && !insn_reti && !insn_cfg && !call_busy;
  assign reti_done = stb_late && insn_last && insn_reti;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      call_cnt <= '0;
      ack_stb  <= 1'b0;
      ack_id   <= '0;
      call_vec <= '0;
      in_prog  <= 2'b00;
    end else begin
      ack_stb <= ack_fire;
      if (ack_fire) begin
        call_cnt <= CW'(CALL_CYC);
        ack_id   <= cand_id;
        call_vec <= vec_of(cand_id, VEC_BASE, VEC_STRIDE);
      end else if (stb_late && call_busy) begin
        call_cnt <= call_cnt - 1'b1;
      end
      if (ack_fire) begin
        in_prog[cand_hi] <= 1'b1;
      end else if (reti_done) begin
        if (in_prog[1]) in_prog[1] <= 1'b0;
        else            in_prog[0] <= 1'b0;
      end
    end
  end

  // R9: the acknowledge pulse lasts one clock
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ack_stb |=> !ack_stb);
  // R9: the call window opens with the pulse
  a_r9_busy_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ack_stb |-> call_busy);
  // R9: the call window closes only on a late strobe
  a_r9_busy_ends_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(call_busy) |-> $past(stb_late));
  // R12: no acknowledgement from inside a call window
  a_r12_no_ack_in_call: assert property (@(posedge clk) disable iff (!rst_n)
    ack_stb |-> !$past(call_busy));
  // R8: acknowledgement only at the final cycle of an ordinary instruction
  a_r8_status_gate: assert property (@(posedge clk) disable iff (!rst_n)
    ack_stb |-> ($past(stb_late) && $past(insn_last) && !$past(insn_reti) && !$past(insn_cfg)));
  // R10: an acknowledged routine is always marked in progress
  a_r10_marked: assert property (@(posedge clk) disable iff (!rst_n)
    ack_stb |-> (in_prog != 2'b00));
endmodule

// File: rtl/irq_front.sv
module irq_front
  import irq_pkg::*;
#(
  parameter int CALL_CYC   = 2,
  parameter int VEC_BASE   = 3,
  parameter int VEC_STRIDE = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stb_early,
  input  logic       stb_late,
  input  logic [1:0] ext_n,
  input  logic [1:0] ext_edge,
  input  logic       t0_ovf,
  input  logic       t1_ovf,
  input  logic       ser_rx,
  input  logic       ser_tx,
  input  logic       t2_ovf,
  input  logic       t2_ext,
  input  logic [7:0] flag_clr,
  input  logic       glb_en,
  input  logic [5:0] src_en,
  input  logic [5:0] pri_reg,
  input  logic       insn_last,
  input  logic       insn_reti,
  input  logic       insn_cfg,
  output logic [7:0] flag_q,
  output logic [1:0] in_prog,
  output logic       ack_stb,
  output logic [2:0] ack_id,
  output logic       call_busy,
  output logic [7:0] call_vec
);
  logic [NSRC-1:0] src_req;
  logic            cand_valid, cand_hi, ack_fire;
  logic [IDW-1:0]  cand_id;

  irq_capture u_cap (
    .clk(clk), .rst_n(rst_n), .stb_early(stb_early), .stb_late(stb_late),
    .ext_n(ext_n), .ext_edge(ext_edge), .tmr_ovf({t1_ovf, t0_ovf}),
    .ser_rx(ser_rx), .ser_tx(ser_tx), .t2_ovf(t2_ovf), .t2_ext(t2_ext),
    .flag_clr(flag_clr), .ack_fire(ack_fire), .ack_src(cand_id),
    .flag_q(flag_q), .src_req(src_req)
  );

  irq_arbiter u_arb (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .glb_en(glb_en),
    .src_en(src_en), .pri_reg(pri_reg), .in_prog(in_prog),
    .cand_valid(cand_valid), .cand_id(cand_id), .cand_hi(cand_hi)
  );

  irq_sequencer #(.CALL_CYC(CALL_CYC), .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)) u_seq (
    .clk(clk), .rst_n(rst_n), .stb_late(stb_late), .cand_valid(cand_valid),
    .cand_id(cand_id), .cand_hi(cand_hi), .insn_last(insn_last),
    .insn_reti(insn_reti), .insn_cfg(insn_cfg), .ack_fire(ack_fire),
    .ack_stb(ack_stb), .ack_id(ack_id), .call_busy(call_busy),
    .call_vec(call_vec), .in_prog(in_prog)
  );

  // R11: a timer overflow flag is gone right after its own acknowledgement
  a_r11_timer_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_stb && (ack_id == 3'd1) && !$past(t0_ovf)) |-> !flag_q[1]);
endmodule

// File: tb/irq_front_tb.sv
module irq_front_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stb_early = 1'b0, stb_late = 1'b0;
  logic [1:0] ext_n = 2'b11, ext_edge = 2'b11;
  logic t0_ovf = 0, t1_ovf = 0, ser_rx = 0, ser_tx = 0, t2_ovf = 0, t2_ext = 0;
  logic [7:0] flag_clr = '0;
  logic glb_en = 1'b1;
  logic [5:0] src_en = 6'h3f, pri_reg = 6'h00;
  logic insn_last = 1'b1, insn_reti = 1'b0, insn_cfg = 1'b0;
  logic [7:0] flag_q, call_vec;
  logic [1:0] in_prog;
  logic ack_stb, call_busy;
  logic [2:0] ack_id;

  int checks = 0, fails = 0, ack_cnt = 0, last_id = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_front u_dut (
    .clk(clk), .rst_n(rst_n), .stb_early(stb_early), .stb_late(stb_late),
    .ext_n(ext_n), .ext_edge(ext_edge), .t0_ovf(t0_ovf), .t1_ovf(t1_ovf),
    .ser_rx(ser_rx), .ser_tx(ser_tx), .t2_ovf(t2_ovf), .t2_ext(t2_ext),
    .flag_clr(flag_clr), .glb_en(glb_en), .src_en(src_en), .pri_reg(pri_reg),
    .insn_last(insn_last), .insn_reti(insn_reti), .insn_cfg(insn_cfg),
    .flag_q(flag_q), .in_prog(in_prog), .ack_stb(ack_stb), .ack_id(ack_id),
    .call_busy(call_busy), .call_vec(call_vec)
  );

  always @(negedge clk) begin
    if (rst_n && ack_stb) begin
      ack_cnt = ack_cnt + 1;
      last_id = int'(ack_id);
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_vec(input int id);
    return (id << 3) | 3;
  endfunction

  // One machine cycle: twelve clocks, early strobe on clock 3, late strobe on clock 9.
  task automatic mc();
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      stb_early = (k == 3);
      stb_late  = (k == 9);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    ext_n = 2'b11; ext_edge = 2'b11;
    t0_ovf = 0; t1_ovf = 0; ser_rx = 0; ser_tx = 0; t2_ovf = 0; t2_ext = 0;
    flag_clr = '0; glb_en = 1'b1; src_en = 6'h3f; pri_reg = 6'h00;
    insn_last = 1'b1; insn_reti = 1'b0; insn_cfg = 1'b0;
    stb_early = 1'b0; stb_late = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic drive_src(input int i, input bit on);
    case (i)
      0: ext_n[0] = ~on;
      1: t0_ovf = on;
      2: ext_n[1] = ~on;
      3: t1_ovf = on;
      4: ser_rx = on;
      default: t2_ext = on;
    endcase
  endtask

  task automatic sw_clear(input logic [7:0] m);
    @(negedge clk); flag_clr = m;
    @(negedge clk); flag_clr = '0;
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    int base, win;
    // Reset state (R10)
    do_reset();
    @(negedge clk);
    chk("R10 reset flags", int'(flag_q), 0);
    chk("R10 reset in_prog", int'(in_prog), 0);
    chk("R10 reset call_busy", int'(call_busy), 0);

    // Pair sweep: R3, R6, R9, R10
    for (int v = 0; v < 2; v++) begin
      for (int a = 0; a < 6; a++) begin
        for (int b = 0; b < 6; b++) begin
          if (a != b) begin
            do_reset();
            pri_reg = (v != 0) ? 6'(1 << b) : 6'h00;
            base = ack_cnt;
            drive_src(a, 1'b1); drive_src(b, 1'b1);
            mc();
            chk("R3 not polled in capture cycle", ack_cnt - base, 0);
            drive_src(a, 1'b0); drive_src(b, 1'b0);
            mc();
            win = (v != 0) ? b : ((a < b) ? a : b);
            chk("R3 polled next cycle", ack_cnt - base, 1);
            chk("R6 winner", last_id, win);
            chk("R9 vector", int'(call_vec), exp_vec(win));
            chk("R10 level bit", int'(in_prog), (v != 0) ? 2 : 1);
          end
        end
      end
    end

    // R1 level mode follows pin; R11 level flag survives ack; re-entry after one instruction
    do_reset();
    ext_edge = 2'b00; glb_en = 1'b0;
    ext_n[0] = 1'b0; mc();
    chk("R1 level flag set", int'(flag_q[0]), 1);
    ext_n[0] = 1'b1; mc();
    chk("R1 level flag follows release", int'(flag_q[0]), 0);
    sw_clear(8'h00);
    ext_n[0] = 1'b0; mc();
    base = ack_cnt; glb_en = 1'b1; mc();
    chk("R1 level ack", ack_cnt - base, 1);
    chk("R11 level flag kept", int'(flag_q[0]), 1);
    sw_clear(8'h01);
    chk("R1 level ignores flag_clr", int'(flag_q[0]), 1);
    mc(); mc();
    chk("R9 busy ended", int'(call_busy), 0);
    chk("R7 same level blocked", ack_cnt - base, 1);
    insn_reti = 1'b1; mc(); insn_reti = 1'b0;
    chk("R8 no ack on reti", ack_cnt - base, 1);
    chk("R10 reti clears low", int'(in_prog), 0);
    mc();
    chk("R8 ack after one instruction", ack_cnt - base, 2);

    // R2 edge mode
    do_reset();
    glb_en = 1'b0; ext_n[1] = 1'b0; mc();
    chk("R2 edge sets flag", int'(flag_q[2]), 1);
    sw_clear(8'h04);
    mc();
    chk("R2 held low no reset", int'(flag_q[2]), 0);
    ext_n[1] = 1'b1; mc();
    ext_n[1] = 1'b0; mc();
    chk("R2 new edge sets flag", int'(flag_q[2]), 1);
    base = ack_cnt; glb_en = 1'b1; mc();
    chk("R2 edge ack", last_id, 2);
    chk("R11 edge flag cleared", int'(flag_q[2]), 0);

    // R4 timer 2 overflow in the same machine cycle
    do_reset();
    base = ack_cnt; t2_ovf = 1'b1; mc(); t2_ovf = 1'b0;
    chk("R4 same cycle ack", ack_cnt - base, 1);
    chk("R4 id", last_id, 5);
    chk("R11 t2 overflow kept", int'(flag_q[6]), 1);

    // R5 enables
    do_reset();
    glb_en = 1'b0; t1_ovf = 1'b1; mc(); t1_ovf = 1'b0;
    base = ack_cnt; mc();
    chk("R5 global off", ack_cnt - base, 0);
    glb_en = 1'b1; src_en = 6'h37; mc();
    chk("R5 source off", ack_cnt - base, 0);
    src_en = 6'h3f; mc();
    chk("R5 enabled ack", ack_cnt - base, 1);
    chk("R5 id", last_id, 3);
    chk("R11 timer flag cleared", int'(flag_q[3]), 0);

    // R8 status gating, R11 serial kept and software clear
    do_reset();
    ser_rx = 1'b1; mc(); ser_rx = 1'b0;
    base = ack_cnt;
    insn_last = 1'b0; mc();
    chk("R8 not final cycle", ack_cnt - base, 0);
    insn_last = 1'b1; insn_reti = 1'b1; mc();
    chk("R8 reti blocks", ack_cnt - base, 0);
    insn_reti = 1'b0; insn_cfg = 1'b1; mc();
    chk("R8 config access blocks", ack_cnt - base, 0);
    insn_cfg = 1'b0; mc();
    chk("R8 ack after ordinary insn", ack_cnt - base, 1);
    chk("R11 serial kept", int'(flag_q[4]), 1);
    sw_clear(8'h10);
    chk("R11 software clear", int'(flag_q[4]), 0);

    // R12 call window, R7 preemption, R9 length, R10 unwind order
    do_reset();
    pri_reg = 6'b000010;
    drive_src(0, 1'b1); mc(); drive_src(0, 1'b0);
    base = ack_cnt; mc();
    chk("R12 first ack", ack_cnt - base, 1);
    t0_ovf = 1'b1; mc(); t0_ovf = 1'b0;
    mc();
    chk("R12 blocked in call", ack_cnt - base, 1);
    chk("R9 busy after two cycles", int'(call_busy), 0);
    mc();
    chk("R7 high preempts low", ack_cnt - base, 2);
    chk("R7 id", last_id, 1);
    chk("R10 both levels", int'(in_prog), 3);
    chk("R11 timer0 cleared", int'(flag_q[1]), 0);
    chk("R11 edge ext0 cleared", int'(flag_q[0]), 0);
    chk("R9 busy during call", int'(call_busy), 1);
    mc();
    chk("R9 busy second cycle", int'(call_busy), 1);
    mc();
    chk("R9 busy released", int'(call_busy), 0);
    insn_reti = 1'b1; mc();
    chk("R10 high cleared first", int'(in_prog), 1);
    mc(); insn_reti = 1'b0;
    chk("R10 low cleared", int'(in_prog), 0);

    done = 1'b1;
    report();
  end
endmodule